// File: doc/BRIEF.md
# Transmit Byte Queue with Low-Water Threshold

This block is the transmit queue that sits between a register bus and a serial shift engine. The bus side pushes one byte per cycle into a power-of-two deep synchronous FIFO. The serial side takes bytes from the head of the queue. The head byte is presented combinationally on the pop port, and a pop request consumes it at the next clock edge.

Next to the queue sits a programmable low-water level. A flag is raised whenever the number of queued bytes is strictly less than that level. Software can use the flag to refill the queue before it runs dry. The level register is only as wide as the queue index (log2 of the depth). Wider writes lose their upper bits, so writing all ones and reading the register back gives depth minus one, which lets software find the depth. The block also reports full, empty and the live occupancy.

The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after the reset input rises.

Top module: `tx_wmark_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `level` is 0, `thr_rdata` reads 1 and `below_thr` is 1.
- R2: Bytes leave on `pop_data` in the order in which they were accepted on the push port.
- R3: `full` is 1 exactly when `level` equals DEPTH. A push while full is discarded: occupancy and stored contents stay unchanged.
- R4: `empty` is 1 exactly when `level` is 0. A pop while empty returns 0 on `pop_data` and leaves `level` at 0.
- R5: A push and a pop in the same cycle, with the queue neither full nor empty, leave `level` unchanged. Both bytes keep their order.
- R6: The threshold register holds log2(DEPTH) bits and keeps only the low bits of a write. It reads back zero-extended to 32 bits, so a write of 0xFFFF reads back DEPTH-1.
- R7: `below_thr` is 1 exactly when the current `level` is less than the stored threshold. A threshold of 0 keeps it at 0.
- R8: A threshold write takes effect at the clock edge where `thr_we` is sampled. Before that edge the old value is still read back.
- R9: A push and a pop in the same cycle while full: the pop is taken, the push is discarded, and `level` becomes DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_valid | input | 1 | Push a byte this cycle |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Consume the head byte this cycle |
| pop_data | output | 8 | Head byte, 0 when empty |
| thr_we | input | 1 | Write the threshold register |
| thr_wdata | input | 32 | Threshold write value; only the low log2(DEPTH) bits are kept |
| thr_rdata | output | 32 | Threshold read value, zero-extended |
| level | output | CW (5) | Number of queued bytes |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no bytes |
| below_thr | output | 1 | Occupancy is under the threshold |

## Verification
The queue is exercised in several ways:
- Short bursts of pushes followed by drains check ordering.
- A complete fill, followed by an extra push, checks that the overflow byte is dropped. Popping the queue afterwards shows that no stored byte was overwritten.
- Pushes paired with pops, at mid occupancy, when full and when empty, separate the three occupancy cases of a simultaneous push and pop.
- Pops from an empty queue show the zero output and that the occupancy does not wrap.

For the threshold register:
- Writes of 0xFFFF, 0x23 and 0x10 separate correct truncation from a register that is too wide.
- A read taken in the write cycle shows when the new value takes effect.
- Rising and falling occupancy across a threshold of 4, and a threshold of 0, check the strict less-than comparison.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned TXQ_BYTE_W = 8;
  localparam int unsigned TXQ_BUS_W  = 32;
  typedef logic [TXQ_BYTE_W-1:0] txq_byte_t;
endpackage

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  txq_byte_t                  push_data,
  input  logic                       pop_req,
  output txq_byte_t                  pop_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  txq_byte_t         mem [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [AW-1:0]     rptr_q, rptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_valid & ~full;
  assign pop_ok  = pop_req & ~empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = wptr_q + 1'b1;
    if (pop_ok)  rptr_d = rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  assign pop_data = empty ? '0 : mem[rptr_q];
  assign level    = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  assert_full_push_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop_req) |=> $stable(cnt_q));

  assert_empty_pop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_valid) |=> (cnt_q == '0));

  assert_pair_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !empty && push_valid && pop_req) |=> $stable(cnt_q));

  assert_full_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && pop_req) |=> (cnt_q == FULL_CNT - 1'b1));
endmodule

// File: rtl/txq_wmark.sv
module txq_wmark
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [TXQ_BUS_W-1:0]       wr_data,
  input  logic [$clog2(DEPTH):0]     level,
  output logic [TXQ_BUS_W-1:0]       rd_data,
  output logic                       below
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW-1:0] thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = wr_data[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= AW'(1);
    else        thr_q <= thr_d;
  end

  assign rd_data = {{(TXQ_BUS_W-AW){1'b0}}, thr_q};
  assign below   = (level < {1'b0, thr_q});

  assert_thr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[AW-1:0] == $past(wr_data[AW-1:0])));
endmodule

// File: rtl/tx_wmark_fifo.sv
module tx_wmark_fifo
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [7:0]                 push_data,
  input  logic                       pop_req,
  output logic [7:0]                 pop_data,
  input  logic                       thr_we,
  input  logic [31:0]                thr_wdata,
  output logic [31:0]                thr_rdata,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty,
  output logic                       below_thr
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push_valid (push_valid),
    .push_data  (push_data),
    .pop_req    (pop_req),
    .pop_data   (pop_data),
    .level      (level),
    .full       (full),
    .empty      (empty)
  );

  txq_wmark #(.DEPTH(DEPTH)) u_wmark (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (thr_we),
    .wr_data (thr_wdata),
    .level   (level),
    .rd_data (thr_rdata),
    .below   (below_thr)
  );
endmodule

// File: tb/tx_wmark_fifo_bench.sv
module tx_wmark_fifo_bench;
  localparam int DEPTH    = 16;
  localparam int CW       = $clog2(DEPTH) + 1;
  localparam int CLK_PER  = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_valid;
  logic [7:0]    push_data;
  logic          pop_req;
  logic [7:0]    pop_data;
  logic          thr_we;
  logic [31:0]   thr_wdata;
  logic [31:0]   thr_rdata;
  logic [CW-1:0] level;
  logic          full, empty, below_thr;

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_on = 0;
  bit done   = 0;
  int thr_m  = 1;
  logic [7:0] exp_q [$];

  always #(CLK_PER/2) clk = ~clk;

  tx_wmark_fifo #(.DEPTH(DEPTH)) u_tx_wmark_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .thr_rdata(thr_rdata), .level(level), .full(full), .empty(empty),
    .below_thr(below_thr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic pv, input logic [7:0] pd, input logic pr,
                       input logic we = 1'b0, input logic [31:0] wd = 32'h0);
    @(posedge clk);
    #1;
    push_valid = pv; push_data = pd; pop_req = pr; thr_we = we; thr_wdata = wd;
  endtask

  // Scoreboard monitor: compares outputs before the edge, then applies the edge to the model
  always @(negedge clk) begin
    if (mon_on) begin
      int sz;
      sz = exp_q.size();
      chk("R5 level tracks model", int'(level), sz);
      chk("R3 full flag", int'(full), int'(sz == DEPTH));
      chk("R4 empty flag", int'(empty), int'(sz == 0));
      chk("R7 below_thr", int'(below_thr), int'(sz < thr_m));
      chk("R6 threshold readback", int'(thr_rdata), thr_m);
      if (pop_req) begin
        if (sz > 0) begin
          chk("R2 pop order", int'(pop_data), int'(exp_q[0]));
          void'(exp_q.pop_front());
        end else begin
          chk("R4 pop on empty returns zero", int'(pop_data), 0);
        end
      end
      if (push_valid && sz < DEPTH) exp_q.push_back(push_data);
      if (thr_we) thr_m = int'(thr_wdata) & (DEPTH - 1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push_valid = 0; push_data = 0; pop_req = 0; thr_we = 0; thr_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset empty", int'(empty), 1);
    chk("R1 reset full", int'(full), 0);
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset threshold", int'(thr_rdata), 1);
    chk("R1 reset below_thr", int'(below_thr), 1);
    mon_on = 1;

    // R6: all-ones write reveals depth-1
    drive(0, 8'h0, 0, 1'b1, 32'h0000_FFFF);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R6 all-ones readback", int'(thr_rdata), DEPTH - 1);

    // R8: old value visible in the write cycle, new value after the edge
    drive(0, 8'h0, 0, 1'b1, 32'h23);
    @(negedge clk);
    chk("R8 old value during write", int'(thr_rdata), DEPTH - 1);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R8 R6 truncated new value", int'(thr_rdata), 3);

    // R7: threshold 0 never reports below
    drive(0, 8'h0, 0, 1'b1, 32'h10);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R7 threshold zero", int'(below_thr), 0);
    chk("R6 0x10 truncates to 0", int'(thr_rdata), 0);

    drive(0, 8'h0, 0, 1'b1, 32'h4);
    for (int i = 0; i < 5; i++) begin
      drive(1, 8'hA0 + 8'(i), 0);
      @(negedge clk);
      chk("R7 below while filling", int'(below_thr), int'(i < 4));
    end
    for (int i = 0; i < 5; i++) drive(0, 8'h0, 1);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R2 drained", int'(empty), 1);

    // R3: fill, then overflow push
    for (int i = 0; i < DEPTH; i++) drive(1, 8'h40 + 8'(i), 0);
    drive(1, 8'hEE, 0);
    @(negedge clk);
    chk("R3 full after DEPTH pushes", int'(full), 1);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R3 overflow push dropped", int'(level), DEPTH);

    // R9: push+pop while full
    drive(1, 8'h77, 1);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R9 full pair level", int'(level), DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++) drive(0, 8'h0, 1);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R3 R9 drained after full", int'(level), 0);

    // R4: pop while empty
    drive(0, 8'h0, 1);
    @(negedge clk);
    chk("R4 empty pop data", int'(pop_data), 0);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R4 no underflow", int'(level), 0);

    // R5: paired push/pop at mid occupancy
    for (int i = 0; i < 3; i++) drive(1, 8'h10 + 8'(i), 0);
    for (int i = 0; i < 6; i++) drive(1, 8'h80 + 8'(i), 1);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R5 paired ops keep level", int'(level), 3);
    for (int i = 0; i < 3; i++) drive(0, 8'h0, 1);
    drive(1, 8'h55, 1);
    drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R4 pair on empty keeps push", int'(level), 1);
    drive(0, 8'h0, 1);
    drive(0, 8'h0, 0);
    repeat (2) drive(0, 8'h0, 0);
    @(negedge clk);
    chk("R2 final empty", int'(empty), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule